// File: doc/BRIEF.md
# Conditional Branch and Skip Resolver

This unit decides where control flow goes next for an 8-bit RISC core when the instruction is a conditional relative branch, a signed-compare branch, or a skip. The core presents an instruction with `issue_i`. Along with it come the current word address, a signed 7-bit displacement, the status byte, a flag index, the value of a register or I/O bit already picked out by the core, two operands for the equality skip, and a flag that says whether the instruction after this one is two words long. One clock later the unit returns three things: the next word address, whether the condition held, and how many cycles the instruction costs.

The control is a two-state machine. `ST_IDLE` means no result is being shown. `ST_RESULT` means the output registers hold a fresh decision. Transition `T_ACCEPT` goes from `ST_IDLE` to `ST_RESULT` when `issue_i` is high. Transition `T_CHAIN` stays in `ST_RESULT` when another issue arrives right behind the first. Transition `T_DRAIN` goes from `ST_RESULT` back to `ST_IDLE` when `issue_i` is low. The result registers load only on an issue, so they keep their values while the unit is idle.

Top module: `branch_skip_unit`

## Requirements
- R1: While reset is asserted and just after it is released, `done_o` is 0, `next_pc_o` is 0, `cycles_o` is 0 and `taken_o` is 0.
- R2: The operation codes are: 0 = branch if flag set, 1 = branch if flag clear, 2 = branch if signed greater-or-equal, 3 = branch if signed less-than, 4 = skip if bit clear, 5 = skip if bit set, 6 = skip if operands equal, 7 = plain step. When a branch condition holds, `next_pc_o` = pc + sign-extended offset + 1, `cycles_o` = 2 and `taken_o` = 1.
- R3: When a branch condition fails, `next_pc_o` = pc + 1, `cycles_o` = 1 and `taken_o` = 0. Code 7 always behaves as a failed condition.
- R4: Codes 0 and 1 test status bit `flag_sel_i`, where bit 0 is carry C, bit 1 is Z, bit 2 is N and bit 3 is V. Code 1 on C is "same or higher" and code 0 on C is "lower".
- R5: Code 2 is taken when N XOR V is 0. Code 3 is taken when N XOR V is 1.
- R6: When a skip condition fails, the unit advances by 1, costs 1 cycle and sets `taken_o` = 0.
- R7: When a skip condition holds, the unit advances by 2 at a cost of 2 cycles if `next_two_word_i` is 0. It advances by 3 at a cost of 3 cycles if `next_two_word_i` is 1. In both cases `taken_o` = 1.
- R8: Code 4 skips when `test_bit_i` is 0. Code 5 skips when `test_bit_i` is 1. Code 6 skips when `cmp_a_i` equals `cmp_b_i`.
- R9: All address arithmetic wraps modulo 2^PC_W. The default PC_W is 11.
- R10: A result appears in the clock after the issue, with `done_o` = 1. In a cycle that follows no issue, `done_o` is 0 and the other outputs keep their values.
- R11: `next_two_word_i` has no effect on branch codes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| op_i | input | 3 | Operation code (see R2) |
| pc_i | input | PC_W | Current word address |
| offset_i | input | OFF_W | Signed relative displacement |
| sreg_i | input | 8 | Status byte |
| flag_sel_i | input | 3 | Status bit index for codes 0 and 1 |
| test_bit_i | input | 1 | Selected register or I/O bit |
| cmp_a_i | input | 8 | First operand for the equality skip |
| cmp_b_i | input | 8 | Second operand for the equality skip |
| next_two_word_i | input | 1 | The following instruction is two words long |
| done_o | output | 1 | A result is present |
| next_pc_o | output | PC_W | Next word address |
| taken_o | output | 1 | The condition held |
| cycles_o | output | 2 | Cycle cost of the instruction |

## Verification
The hardest situations to reach are the wrap cases. One is a taken skip over a two-word instruction sitting at the very top of program memory. The other is a large negative or positive displacement that crosses address zero. Both need exact pc, offset and length values chosen together, so the stimulus pins them directly. A long random run then mixes back-to-back issues, idle gaps and every flag pattern. A behavioural model in the bench follows every cycle, so the hold behaviour during idle gaps is compared as well.

// File: rtl/branch_skip_pkg.sv
package branch_skip_pkg;
    typedef enum logic [2:0] {
        OP_BR_SET   = 3'd0,
        OP_BR_CLR   = 3'd1,
        OP_BR_GE    = 3'd2,
        OP_BR_LT    = 3'd3,
        OP_SKIP_CLR = 3'd4,
        OP_SKIP_SET = 3'd5,
        OP_SKIP_EQ  = 3'd6,
        OP_STEP     = 3'd7
    } op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } state_e;

    localparam int FLAG_Z = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_V = 3;
endpackage

// File: rtl/branch_skip_cond.sv
module branch_skip_cond
    import branch_skip_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] sreg,
    input  logic [2:0]        flag_sel,
    input  logic              test_bit,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    output logic              cond_true,
    output logic              is_skip
);
    logic flag_bit;
    logic sign_lt;

    assign flag_bit = sreg[flag_sel];
    assign sign_lt  = sreg[FLAG_N] ^ sreg[FLAG_V];

    always_comb begin
        cond_true = 1'b0;
        is_skip   = 1'b0;
        unique case (op)
            OP_BR_SET:   cond_true = flag_bit;
            OP_BR_CLR:   cond_true = !flag_bit;
            OP_BR_GE:    cond_true = !sign_lt;
            OP_BR_LT:    cond_true = sign_lt;
            OP_SKIP_CLR: begin is_skip = 1'b1; cond_true = !test_bit; end
            OP_SKIP_SET: begin is_skip = 1'b1; cond_true = test_bit; end
            OP_SKIP_EQ:  begin is_skip = 1'b1; cond_true = (cmp_a == cmp_b); end
            OP_STEP:     cond_true = 1'b0;
        endcase
    end
endmodule

// File: rtl/branch_skip_next.sv
module branch_skip_next #(
    parameter int PC_W  = 11,
    parameter int OFF_W = 7
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic             cond_true,
    input  logic             is_skip,
    input  logic             two_word,
    output logic [PC_W-1:0]  next_pc,
    output logic [1:0]       cycles
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] step;

    assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};

    always_comb begin
        if (!cond_true) begin
            step   = PC_W'(1);
            cycles = 2'd1;
        end else if (is_skip) begin
            step   = two_word ? PC_W'(3) : PC_W'(2);
            cycles = two_word ? 2'd3 : 2'd2;
        end else begin
            step   = off_ext + PC_W'(1);
            cycles = 2'd2;
        end
    end

    assign next_pc = pc + step;
endmodule

// File: rtl/branch_skip_unit.sv
module branch_skip_unit
    import branch_skip_pkg::*;
#(
    parameter int PC_W  = 11,
    parameter int OFF_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [2:0]       op_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic [7:0]       sreg_i,
    input  logic [2:0]       flag_sel_i,
    input  logic             test_bit_i,
    input  logic [7:0]       cmp_a_i,
    input  logic [7:0]       cmp_b_i,
    input  logic             next_two_word_i,
    output logic             done_o,
    output logic [PC_W-1:0]  next_pc_o,
    output logic             taken_o,
    output logic [1:0]       cycles_o
);
    state_e          state_q, state_d;
    logic            cond_true, is_skip;
    logic [PC_W-1:0] calc_pc;
    logic [1:0]      calc_cycles;

    branch_skip_cond #(.DATA_W(8)) u_cond (
        .op        (op_e'(op_i)),
        .sreg      (sreg_i),
        .flag_sel  (flag_sel_i),
        .test_bit  (test_bit_i),
        .cmp_a     (cmp_a_i),
        .cmp_b     (cmp_b_i),
        .cond_true (cond_true),
        .is_skip   (is_skip)
    );

    branch_skip_next #(.PC_W(PC_W), .OFF_W(OFF_W)) u_next (
        .pc        (pc_i),
        .offset    (offset_i),
        .cond_true (cond_true),
        .is_skip   (is_skip),
        .two_word  (next_two_word_i),
        .next_pc   (calc_pc),
        .cycles    (calc_cycles)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (issue_i) state_d = ST_RESULT;
            ST_RESULT: if (!issue_i) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc_o <= '0;
            taken_o   <= 1'b0;
            cycles_o  <= 2'd0;
        end else if (issue_i) begin
            next_pc_o <= calc_pc;
            taken_o   <= cond_true;
            cycles_o  <= calc_cycles;
        end
    end

    assign done_o = (state_q == ST_RESULT);

    AST_ISSUE_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> done_o); // R10
    AST_IDLE_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> (!done_o && $stable(next_pc_o) && $stable(cycles_o))); // R10
    AST_NOT_TAKEN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !taken_o) |-> (cycles_o == 2'd1)); // R6
    AST_SKIP_STEP_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_i >= 3'd4 && op_i <= 3'd6) |=>
        (PC_W'(next_pc_o - $past(pc_i)) == PC_W'(cycles_o))); // R7
    AST_BRANCH_TAKEN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_i <= 3'd3) |=> (taken_o == (cycles_o == 2'd2))); // R2
endmodule

// File: tb/branch_skip_unit_bench.sv
module branch_skip_unit_bench;
    localparam int PC_W  = 11;
    localparam int OFF_W = 7;
    localparam int PC_MOD = 1 << PC_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             issue_i = 1'b0;
    logic [2:0]       op_i = '0;
    logic [PC_W-1:0]  pc_i = '0;
    logic [OFF_W-1:0] offset_i = '0;
    logic [7:0]       sreg_i = '0;
    logic [2:0]       flag_sel_i = '0;
    logic             test_bit_i = 1'b0;
    logic [7:0]       cmp_a_i = '0;
    logic [7:0]       cmp_b_i = '0;
    logic             next_two_word_i = 1'b0;
    logic             done_o;
    logic [PC_W-1:0]  next_pc_o;
    logic             taken_o;
    logic [1:0]       cycles_o;

    int checks = 0;
    int errors = 0;
    int cycle_cnt = 0;
    bit finished = 1'b0;

    int    exp_done = 0, exp_pc = 0, exp_taken = 0, exp_cyc = 0;
    string exp_tag = "R1";
    string issue_tag = "R10";

    always #2 clk = ~clk;

    branch_skip_unit #(.PC_W(PC_W), .OFF_W(OFF_W)) u_branch_skip_unit (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i), .pc_i(pc_i),
        .offset_i(offset_i), .sreg_i(sreg_i), .flag_sel_i(flag_sel_i),
        .test_bit_i(test_bit_i), .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i),
        .next_two_word_i(next_two_word_i), .done_o(done_o), .next_pc_o(next_pc_o),
        .taken_o(taken_o), .cycles_o(cycles_o)
    );

    // Behavioural reference, advanced at every rising edge.
    always @(posedge clk) begin
        cycle_cnt++;
        if (!rst_n) begin
            exp_done = 0; exp_pc = 0; exp_taken = 0; exp_cyc = 0; exp_tag = "R1";
        end else if (issue_i) begin
            int  nflag, vflag, cond, skip, step, off;
            nflag = sreg_i[2]; vflag = sreg_i[3];
            skip  = (op_i >= 4 && op_i <= 6);
            case (op_i)
                0: cond = sreg_i[flag_sel_i];
                1: cond = !sreg_i[flag_sel_i];
                2: cond = ((nflag ^ vflag) == 0);
                3: cond = ((nflag ^ vflag) == 1);
                4: cond = (test_bit_i == 0);
                5: cond = (test_bit_i == 1);
                6: cond = (cmp_a_i == cmp_b_i);
                default: cond = 0;
            endcase
            off = $signed(offset_i);
            if (!cond) begin step = 1; exp_cyc = 1; end
            else if (skip) begin step = next_two_word_i ? 3 : 2; exp_cyc = step; end
            else begin step = off + 1; exp_cyc = 2; end
            exp_pc    = (((int'(pc_i) + step) % PC_MOD) + PC_MOD) % PC_MOD;
            exp_taken = cond;
            exp_done  = 1;
            exp_tag   = issue_tag;
        end else begin
            exp_done = 0;
            exp_tag  = "R10";
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (int'(done_o) != exp_done || int'(next_pc_o) != exp_pc ||
                int'(taken_o) != exp_taken || int'(cycles_o) != exp_cyc) begin
                errors++;
                $display("FAIL %s: done/pc/taken/cycles actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                         exp_tag, done_o, next_pc_o, taken_o, cycles_o,
                         exp_done, exp_pc, exp_taken, exp_cyc);
            end
        end
    end

    always @(posedge clk) begin
        if (cycle_cnt > 100000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic drive(input string tag, input int op, input int pc, input int off,
                         input int sreg, input int fsel, input int tbit,
                         input int a, input int b, input int two);
        @(negedge clk);
        issue_tag       = tag;
        issue_i         = 1'b1;
        op_i            = 3'(op);
        pc_i            = PC_W'(pc);
        offset_i        = OFF_W'(off);
        sreg_i          = 8'(sreg);
        flag_sel_i      = 3'(fsel);
        test_bit_i      = tbit[0];
        cmp_a_i         = 8'(a);
        cmp_b_i         = 8'(b);
        next_two_word_i = two[0];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            issue_i = 1'b0;
            op_i    = 3'($urandom_range(0, 7));
            pc_i    = PC_W'($urandom);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;               // R1 checked by the compare during and after reset
        idle(2);
        drive("R2", 0, 100, 5, 8'h01, 0, 0, 0, 0, 0);       // lower: C set, taken
        drive("R3", 0, 100, 5, 8'h00, 0, 0, 0, 0, 0);       // not taken
        drive("R4", 1, 50, -10, 8'h00, 1, 0, 0, 0, 0);      // Z clear, taken backward
        drive("R4", 1, 50, 3, 8'h01, 0, 0, 0, 0, 0);        // same-or-higher fails
        idle(1);
        drive("R5", 2, 200, 7, 8'h0C, 0, 0, 0, 0, 0);       // N=1 V=1 GE taken
        drive("R5", 2, 200, 7, 8'h04, 0, 0, 0, 0, 0);       // N=1 V=0 GE not taken
        drive("R5", 3, 200, -2, 8'h08, 0, 0, 0, 0, 0);      // LT taken
        drive("R5", 3, 200, -2, 8'h00, 0, 0, 0, 0, 0);      // LT not taken
        drive("R7", 4, 300, 0, 0, 0, 0, 0, 0, 0);           // skip one word
        drive("R7", 4, 300, 0, 0, 0, 0, 0, 0, 1);           // skip two words
        drive("R6", 4, 300, 0, 0, 0, 1, 0, 0, 1);           // no skip
        drive("R8", 5, 400, 0, 0, 0, 1, 0, 0, 0);
        drive("R8", 6, 400, 0, 0, 0, 0, 8'h5A, 8'h5A, 1);
        drive("R8", 6, 400, 0, 0, 0, 0, 8'h5A, 8'h5B, 1);
        drive("R3", 7, 500, 20, 8'hFF, 0, 0, 1, 1, 1);      // plain step
        idle(2);
        drive("R9", 4, 2047, 0, 0, 0, 0, 0, 0, 1);          // wraps to 2
        drive("R9", 0, 3, -64, 8'h02, 1, 0, 0, 0, 0);       // wraps below zero
        drive("R9", 1, 2040, 63, 8'h00, 3, 0, 0, 0, 0);     // wraps above top
        drive("R11", 2, 600, 9, 8'h00, 0, 0, 0, 0, 1);
        drive("R11", 0, 600, 9, 8'h02, 1, 0, 0, 0, 1);
        idle(3);
        for (int i = 0; i < 400; i++) begin
            drive("R8", $urandom_range(0, 7), $urandom, $urandom, $urandom,
                  $urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 3),
                  $urandom_range(0, 3), $urandom_range(0, 1));
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(3);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule